// File: doc/BRIEF.md
# Command-Frame Responder for a Strobed Half-Duplex Serial Bus

This block is the device-side sequencer for a half-duplex serial bus on which the host marks each command by holding a separate active-low strobe line low. An external UART passes in whole received bytes and takes outgoing bytes through a valid/ready handshake. The responder gathers the five-byte command frame sent while the strobe is low and checks the device address and the checksum. When the strobe returns high it replies with a single acknowledge or reject character. It then runs one of three sequences: immediate, host-to-device data, or device-to-host data. Each sequence ends with a one-character status.

Reply characters carry no checksum. Data frames in either direction end with a checksum byte. The checksum is the 8-bit sum with end-around carry: any carry out of bit 7 is added back in. Turnaround delays are counted in clock cycles, derived from a clock-frequency parameter and microsecond parameters, so the minimum gaps hold at any system clock. The opcodes for the three sequence types and the data-frame length are parameters.

States, all named in `cfr_pkg::cfr_state_e`:
- `ST_IDLE`: waiting for the strobe.
- `ST_CMD_RX`: collecting the command frame.
- `ST_CMD_END`: frame complete, waiting for the strobe to rise.
- `ST_DATA_RX`: collecting inbound data.
- `ST_ACK2_GAP`: wait before the data reply.
- `ST_STAT_GAP`: wait before the status byte.
- `ST_RD_LOAD`: picking the next outbound data byte.
- `ST_SEND`: byte offered to the UART.
- `ST_DRAIN`: waiting for the UART to finish.

Transitions:
- Strobe fall, from any state → `ST_CMD_RX`.
- Fifth byte → `ST_CMD_END`.
- Strobe rise before five bytes → `ST_IDLE`.
- Strobe rise with a bad address or checksum → `ST_IDLE`.
- Strobe rise with a good frame → `ST_SEND`, carrying a return state: `ST_IDLE` after a reject, `ST_DATA_RX` for host-to-device, `ST_STAT_GAP` otherwise.
- Last inbound byte → `ST_ACK2_GAP`.
- Gap expiry → `ST_SEND`.
- Handshake accepted → `ST_DRAIN`.
- UART ready again → the stored return state.
- `ST_RD_LOAD` → `ST_SEND`, looping back until the checksum byte has gone.

Top module: `cfr_responder`

## Requirements
- R1: After reset `tx_valid` and `wr_valid` are low and the block is idle, sending nothing while `cmd_n` stays high.
- R2: A falling `cmd_n` starts collection of five bytes: address, opcode, aux low, aux high, checksum. The opcode appears on `cmd_op` and the aux bytes on `cmd_aux` as {aux high, aux low}. If the address byte differs from `dev_addr`, or the checksum byte differs from the end-around-carry sum of the first four, nothing is transmitted and the block returns to idle.
- R3: An offered byte keeps `tx_valid` high and `tx_data` stable until `tx_ready` is seen high. No further byte is offered until `tx_ready` has returned high after the handshake.
- R4: For a good frame the reply is offered on the cycle after `cmd_n` is first sampled high. The reply is 0x41 when the opcode equals `OP_IMM`, `OP_SEND` or `OP_RECV`; otherwise it is 0x4E and nothing more is sent.
- R5: Immediate sequence: after the 0x41, a status byte follows. It is 0x43 when `exec_err` is low at the end of the status gap and 0x45 when it is high.
- R6: Host-to-device sequence: after the 0x41 the block takes `DLEN` data bytes and a checksum byte. Each data byte is passed out as a one-cycle `wr_valid` pulse with the byte on `wr_data`.
- R7: The reply to inbound data is accepted no sooner than `ACK2_US` microseconds' worth of cycles after the last inbound byte, and within 16 cycles beyond that. It is 0x41 followed by status when the data checksum matches. It is 0x4E with nothing after it when the checksum does not match.
- R8: The status byte is accepted no sooner than `STAT_US` microseconds' worth of cycles after the UART reports the previous reply finished.
- R9: Device-to-host sequence: after 0x41 and then 0x43, the block sends `rd_data` for `rd_idx` 0 to `DLEN`-1, then their checksum. After a 0x45 status no data follows.
- R10: A falling `cmd_n` in any state drops the current transaction, so no reply from it is sent, and starts a new frame collection.
- R11: If `cmd_n` rises before five bytes have arrived, nothing is sent and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_n | input | 1 | Active-low command strobe, synchronous to clk |
| dev_addr | input | 8 | Address this device answers to |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the UART |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART idle and able to take a byte |
| exec_err | input | 1 | Operation failed; selects the error status |
| cmd_op | output | 8 | Opcode of the last command frame |
| cmd_aux | output | 16 | Aux bytes of the last command frame |
| wr_valid | output | 1 | Inbound data byte strobe |
| wr_data | output | 8 | Inbound data byte |
| rd_idx | output | $clog2(DLEN+1) | Index of the outbound data byte requested |
| rd_data | input | 8 | Outbound data byte at rd_idx |

## Verification
The gap properties assume that the host is silent during each turnaround. No `rx_valid` may arrive between the last data byte and the reply, and the strobe does not fall during a gap. The stimulus keeps to this by sending every frame in full before it waits for the replies. The handshake properties assume the UART drops `tx_ready` on the cycle after it accepts a byte and keeps it low until the byte has left the line. The bench UART model does exactly that, holding ready low for a fixed twenty cycles. Strobe and byte inputs are driven on the falling clock edge, so the block always sees them as synchronous.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_RX,
        ST_CMD_END,
        ST_DATA_RX,
        ST_ACK2_GAP,
        ST_STAT_GAP,
        ST_RD_LOAD,
        ST_SEND,
        ST_DRAIN
    } cfr_state_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_IMM,
        KIND_SEND,
        KIND_RECV
    } cfr_kind_e;

    localparam logic [7:0] CH_ACK  = 8'h41;
    localparam logic [7:0] CH_NAK  = 8'h4E;
    localparam logic [7:0] CH_DONE = 8'h43;
    localparam logic [7:0] CH_ERR  = 8'h45;

    // 8-bit add with the carry folded back into bit 0
    function automatic logic [7:0] fold_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

endpackage

// File: rtl/cfr_csum.sv
module cfr_csum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] din,
    output logic [7:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (add) sum <= cfr_pkg::fold_add(sum, din);
    end
endmodule

// File: rtl/cfr_gap_timer.sv
module cfr_gap_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (!run)  cnt <= '0;
        else if (!done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfr_responder.sv
module cfr_responder #(
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned DLEN    = 128,
    parameter logic [7:0]  OP_IMM  = 8'h53,
    parameter logic [7:0]  OP_SEND = 8'h57,
    parameter logic [7:0]  OP_RECV = 8'h52,
    parameter int unsigned ACK2_US = 1000,
    parameter int unsigned STAT_US = 300
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_n,
    input  logic [7:0]                 dev_addr,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_data,
    output logic                       tx_valid,
    output logic [7:0]                 tx_data,
    input  logic                       tx_ready,
    input  logic                       exec_err,
    output logic [7:0]                 cmd_op,
    output logic [15:0]                cmd_aux,
    output logic                       wr_valid,
    output logic [7:0]                 wr_data,
    output logic [$clog2(DLEN+1)-1:0]  rd_idx,
    input  logic [7:0]                 rd_data
);
    import cfr_pkg::*;

    localparam int unsigned ACK2_CYC = int'((64'(CLK_HZ) * ACK2_US) / 64'd1_000_000);
    localparam int unsigned STAT_CYC = int'((64'(CLK_HZ) * STAT_US) / 64'd1_000_000);
    localparam int unsigned GAP_MAX  = (ACK2_CYC > STAT_CYC) ? ACK2_CYC : STAT_CYC;
    localparam int TW = $clog2(GAP_MAX + 2);
    localparam int IW = $clog2(DLEN + 1);
    localparam int CW = $clog2(DLEN + 6);
    localparam logic [CW-1:0] LAST = CW'(DLEN);

    cfr_state_e st, st_nx, ret, ret_nx;
    cfr_kind_e  kind;
    logic [7:0] tx_byte, tx_byte_nx;
    logic [CW-1:0] cnt;
    logic cmd_q, cmd_fall, addr_ok, sum_ok;
    logic cs_clr, cs_add, gap_run, gap_done;
    logic [7:0] cs_din, cs_sum;
    logic [TW-1:0] gap_limit;

    assign cmd_fall = cmd_q && !cmd_n;

    always_comb begin
        if      (cmd_op == OP_IMM)  kind = KIND_IMM;
        else if (cmd_op == OP_SEND) kind = KIND_SEND;
        else if (cmd_op == OP_RECV) kind = KIND_RECV;
        else                        kind = KIND_NONE;
    end

    // next-state process
    always_comb begin
        st_nx      = st;
        ret_nx     = ret;
        tx_byte_nx = tx_byte;
        if (cmd_fall) begin
            st_nx = ST_CMD_RX;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_CMD_RX: begin
                    if (rx_valid && cnt == CW'(4)) st_nx = ST_CMD_END;
                    else if (cmd_n)                st_nx = ST_IDLE;
                end
                ST_CMD_END: if (cmd_n) begin
                    if (!(addr_ok && sum_ok)) begin
                        st_nx = ST_IDLE;
                    end else if (kind == KIND_NONE) begin
                        st_nx = ST_SEND; tx_byte_nx = CH_NAK; ret_nx = ST_IDLE;
                    end else begin
                        st_nx = ST_SEND; tx_byte_nx = CH_ACK;
                        ret_nx = (kind == KIND_SEND) ? ST_DATA_RX : ST_STAT_GAP;
                    end
                end
                ST_DATA_RX: if (rx_valid && cnt == LAST) st_nx = ST_ACK2_GAP;
                ST_ACK2_GAP: if (gap_done) begin
                    st_nx      = ST_SEND;
                    tx_byte_nx = sum_ok ? CH_ACK : CH_NAK;
                    ret_nx     = sum_ok ? ST_STAT_GAP : ST_IDLE;
                end
                ST_STAT_GAP: if (gap_done) begin
                    st_nx      = ST_SEND;
                    tx_byte_nx = exec_err ? CH_ERR : CH_DONE;
                    ret_nx     = (kind == KIND_RECV && !exec_err) ? ST_RD_LOAD : ST_IDLE;
                end
                ST_RD_LOAD: begin
                    st_nx      = ST_SEND;
                    tx_byte_nx = (cnt == LAST) ? cs_sum : rd_data;
                    ret_nx     = (cnt == LAST) ? ST_IDLE : ST_RD_LOAD;
                end
                ST_SEND:  if (tx_ready) st_nx = ST_DRAIN;
                ST_DRAIN: if (tx_ready) st_nx = ret;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    // state register and frame-field registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE; ret <= ST_IDLE; tx_byte <= '0; cmd_q <= 1'b1;
            cnt <= '0; addr_ok <= 1'b0; sum_ok <= 1'b0;
            cmd_op <= '0; cmd_aux <= '0;
        end else begin
            st <= st_nx; ret <= ret_nx; tx_byte <= tx_byte_nx; cmd_q <= cmd_n;
            if (cmd_fall) begin
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_CMD_RX: if (rx_valid) begin
                        cnt <= cnt + 1'b1;
                        case (cnt)
                            CW'(0):  addr_ok <= (rx_data == dev_addr);
                            CW'(1):  cmd_op <= rx_data;
                            CW'(2):  cmd_aux[7:0] <= rx_data;
                            CW'(3):  cmd_aux[15:8] <= rx_data;
                            default: sum_ok <= (rx_data == cs_sum);
                        endcase
                    end
                    ST_CMD_END:  cnt <= '0;
                    ST_DATA_RX: if (rx_valid) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) sum_ok <= (rx_data == cs_sum);
                    end
                    ST_STAT_GAP: cnt <= '0;
                    ST_RD_LOAD:  cnt <= cnt + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // checksum and turnaround timer
    assign cs_clr = cmd_fall || (st == ST_CMD_END && cmd_n) || (st == ST_STAT_GAP && gap_done);
    assign cs_add = (st == ST_CMD_RX  && rx_valid && cnt < CW'(4))
                 || (st == ST_DATA_RX && rx_valid && cnt < LAST)
                 || (st == ST_RD_LOAD && cnt < LAST);
    assign cs_din = (st == ST_RD_LOAD) ? rd_data : rx_data;

    cfr_csum u_csum (
        .clk(clk), .rst_n(rst_n), .clr(cs_clr), .add(cs_add), .din(cs_din), .sum(cs_sum)
    );

    assign gap_run   = (st == ST_ACK2_GAP) || (st == ST_STAT_GAP);
    assign gap_limit = (st == ST_ACK2_GAP) ? TW'(ACK2_CYC) : TW'(STAT_CYC);

    cfr_gap_timer #(.W(TW)) u_gap (
        .clk(clk), .rst_n(rst_n), .run(gap_run), .limit(gap_limit), .done(gap_done)
    );

    // output process
    always_comb begin
        tx_valid = (st == ST_SEND);
        tx_data  = tx_byte;
        wr_valid = (st == ST_DATA_RX) && rx_valid && (cnt < LAST) && !cmd_fall;
        wr_data  = rx_data;
        rd_idx   = cnt[IW-1:0];
    end
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
    parameter int unsigned ACK2_CYC = 1000,
    parameter int unsigned STAT_CYC = 300
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_n,
    input logic               rx_valid,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [7:0]         tx_data,
    input logic               wr_valid,
    input cfr_pkg::cfr_state_e st
);
    import cfr_pkg::*;

    logic [31:0] rx_quiet, ready_quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_quiet <= '0; ready_quiet <= '0;
        end else begin
            if (rx_valid) rx_quiet <= '0;
            else if (rx_quiet != '1) rx_quiet <= rx_quiet + 1'b1;
            if (!tx_ready || tx_valid) ready_quiet <= '0;
            else if (ready_quiet != '1) ready_quiet <= ready_quiet + 1'b1;
        end
    end

    // R3: offered byte held until taken
    a_r3_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R3: input contract, UART busy right after a handshake
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R4: reply follows the strobe rise without delay
    a_r4_prompt_reply: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_n) && st == ST_CMD_END) |=> (st == ST_SEND || st == ST_IDLE));

    // R7: minimum gap after the last inbound byte
    a_r7_ack2_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && $past(st) == ST_ACK2_GAP) |-> (rx_quiet >= ACK2_CYC));

    // R8: minimum gap before the status byte
    a_r8_status_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEND && $past(st) == ST_STAT_GAP) |-> (ready_quiet >= STAT_CYC));

    // R10: strobe fall silences the block
    a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_n) |=> (!tx_valid && !wr_valid));
endmodule

bind cfr_responder cfr_checker #(.ACK2_CYC(ACK2_CYC), .STAT_CYC(STAT_CYC)) u_cfr_checker (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .rx_valid(rx_valid),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .wr_valid(wr_valid), .st(st)
);

// File: tb/cfr_responder_bench.sv
`timescale 1ns/1ps
module cfr_responder_bench;
    localparam int unsigned CLK_HZ = 4_000_000;
    localparam int unsigned DLEN   = 4;
    localparam int ACK2_CYC = 4000;   // 1000 us at CLK_HZ
    localparam int STAT_CYC = 1200;   // 300 us at CLK_HZ
    localparam int TXLAT    = 20;
    localparam logic [7:0] ADDR = 8'h31;
    localparam int IW = $clog2(DLEN + 1);

    logic clk = 1'b0, rst_n = 1'b0, cmd_n = 1'b1, rx_valid = 1'b0, tx_ready = 1'b1, exec_err = 1'b0;
    logic [7:0] rx_data = '0, tx_data, cmd_op, wr_data, rd_data;
    logic [15:0] cmd_aux;
    logic tx_valid, wr_valid;
    logic [IW-1:0] rd_idx;

    always #2 clk = ~clk;

    assign rd_data = 8'hA0 ^ (8'(rd_idx) * 8'h13);

    cfr_responder #(.CLK_HZ(CLK_HZ), .DLEN(DLEN)) u_cfr_responder (
        .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .dev_addr(ADDR),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .exec_err(exec_err), .cmd_op(cmd_op), .cmd_aux(cmd_aux),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    int checks = 0, fails = 0;
    int cyc = 0, n = 0, wn = 0, busy = 0, t_rx = 0, t_rise = 0;
    logic cmd_prev = 1'b1;
    logic [7:0] tlog [64];
    int         tacc [64];
    logic [7:0] wlog [64];

    // UART model and logging
    always @(posedge clk) begin
        if (tx_valid && tx_ready && n < 64) begin tlog[n] = tx_data; tacc[n] = cyc; n = n + 1; end
        if (wr_valid && wn < 64) begin wlog[wn] = wr_data; wn = wn + 1; end
        if (rx_valid) t_rx = cyc;
        if (cmd_n && !cmd_prev) t_rise = cyc;
        cmd_prev = cmd_n;
        if (busy > 0) begin
            busy = busy - 1;
            if (busy == 0) tx_ready <= 1'b1;
        end else if (tx_valid && tx_ready) begin
            busy = TXLAT;
            tx_ready <= 1'b0;
        end
        cyc = cyc + 1;
    end

    function automatic logic [7:0] fsum(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s = {1'b0, a} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_in(input string req, input string what, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic put(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic host_cmd(input logic [7:0] dev, input logic [7:0] op,
                            input logic [7:0] a0, input logic [7:0] a1, input bit corrupt);
        logic [7:0] cs;
        cs = fsum(fsum(fsum(dev, op), a0), a1);
        if (corrupt) cs = cs ^ 8'h01;
        @(negedge clk); cmd_n = 1'b0;
        repeat (4) @(negedge clk);
        put(dev); put(op); put(a0); put(a1); put(cs);
        repeat (2) @(negedge clk);
        cmd_n = 1'b1;
    endtask

    task automatic expect_log(input string req, input int n0, input int k, input logic [7:0] ev [8]);
        chk(req, "reply count", n - n0, k);
        for (int i = 0; i < k && i < 8 && n0 + i < n; i++)
            chk(req, $sformatf("reply byte %0d", i), tlog[n0 + i], ev[i]);
    endtask

    task automatic t_reset;
        chk("R1", "tx_valid after reset", tx_valid, 0);
        chk("R1", "wr_valid after reset", wr_valid, 0);
        repeat (50) @(negedge clk);
        chk("R1", "bytes sent while idle", n, 0);
    endtask

    task automatic t_immediate(input bit err);
        int n0 = n;
        exec_err = err;
        host_cmd(ADDR, 8'h53, 8'h12, 8'h34, 1'b0);
        repeat (1500) @(negedge clk);
        expect_log("R5", n0, 2, '{8'h41, err ? 8'h45 : 8'h43, 0, 0, 0, 0, 0, 0});
        chk("R2", "cmd_op", cmd_op, 8'h53);
        chk("R2", "cmd_aux", cmd_aux, 16'h3412);
        chk_in("R4", "ack delay after strobe rise", tacc[n0] - t_rise, 1, 2);
        chk_in("R8", "status gap", tacc[n0 + 1] - tacc[n0], STAT_CYC + TXLAT, STAT_CYC + TXLAT + 16);
        exec_err = 1'b0;
    endtask

    task automatic t_unknown_op;
        int n0 = n;
        host_cmd(ADDR, 8'h99, 8'h00, 8'h00, 1'b0);
        repeat (1500) @(negedge clk);
        expect_log("R4", n0, 1, '{8'h4E, 0, 0, 0, 0, 0, 0, 0});
    endtask

    task automatic t_silent;
        int n0 = n;
        host_cmd(8'h32, 8'h53, 8'h00, 8'h00, 1'b0);
        repeat (1500) @(negedge clk);
        chk("R2", "bytes after foreign address", n - n0, 0);
        host_cmd(ADDR, 8'h53, 8'h00, 8'h00, 1'b1);
        repeat (1500) @(negedge clk);
        chk("R2", "bytes after bad checksum", n - n0, 0);
    endtask

    task automatic t_send(input bit corrupt);
        int n0 = n, w0 = wn;
        logic [7:0] cs = 8'h00;
        logic [7:0] d [4] = '{8'hFF, 8'h80, 8'h7F, 8'hC3};
        host_cmd(ADDR, 8'h57, 8'h01, 8'h00, 1'b0);
        repeat (40) @(negedge clk);
        for (int i = 0; i < 4; i++) begin cs = fsum(cs, d[i]); put(d[i]); end
        put(corrupt ? (cs ^ 8'h10) : cs);
        repeat (5800) @(negedge clk);
        if (corrupt) begin
            expect_log("R7", n0, 2, '{8'h41, 8'h4E, 0, 0, 0, 0, 0, 0});
        end else begin
            expect_log("R6", n0, 3, '{8'h41, 8'h41, 8'h43, 0, 0, 0, 0, 0});
            chk("R6", "data strobes", wn - w0, 4);
            for (int i = 0; i < 4; i++) chk("R6", "data byte", wlog[w0 + i], d[i]);
        end
        chk_in("R7", "reply gap after data", tacc[n0 + 1] - t_rx, ACK2_CYC, ACK2_CYC + 16);
    endtask

    task automatic t_receive(input bit err);
        int n0 = n;
        logic [7:0] ev [8];
        logic [7:0] cs = 8'h00;
        exec_err = err;
        ev[0] = 8'h41; ev[1] = err ? 8'h45 : 8'h43;
        for (int i = 0; i < 4; i++) begin
            ev[2 + i] = 8'hA0 ^ (8'(i) * 8'h13);
            cs = fsum(cs, ev[2 + i]);
        end
        ev[6] = cs; ev[7] = 8'h00;
        host_cmd(ADDR, 8'h52, 8'h05, 8'h00, 1'b0);
        repeat (1800) @(negedge clk);
        if (err) expect_log("R9", n0, 2, ev);
        else     expect_log("R9", n0, 7, ev);
        exec_err = 1'b0;
    endtask

    task automatic t_abort;
        int n0 = n;
        host_cmd(ADDR, 8'h57, 8'h00, 8'h00, 1'b0);
        repeat (40) @(negedge clk);
        put(8'h11); put(8'h22);
        host_cmd(ADDR, 8'h53, 8'h00, 8'h00, 1'b0);
        repeat (5800) @(negedge clk);
        expect_log("R10", n0, 3, '{8'h41, 8'h41, 8'h43, 0, 0, 0, 0, 0});
    endtask

    task automatic t_short;
        int n0 = n;
        @(negedge clk); cmd_n = 1'b0;
        repeat (4) @(negedge clk);
        put(ADDR); put(8'h53); put(8'h00);
        cmd_n = 1'b1;
        repeat (1500) @(negedge clk);
        chk("R11", "bytes after short frame", n - n0, 0);
        host_cmd(ADDR, 8'h53, 8'h00, 8'h00, 1'b0);
        repeat (1500) @(negedge clk);
        expect_log("R11", n0, 2, '{8'h41, 8'h43, 0, 0, 0, 0, 0, 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_immediate(1'b0);
        t_immediate(1'b1);
        t_unknown_op();
        t_silent();
        t_send(1'b0);
        t_send(1'b1);
        t_receive(1'b0);
        t_receive(1'b1);
        t_abort();
        t_short();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule